// File: doc/BRIEF.md
# Shared-Comparator Merge Tree Level

This block forms one stage of a merge-sort tree. It has `2*N_OUT` sorted input streams and `N_OUT` sorted output streams. Inputs `2k` and `2k+1` form pair `k`, and that pair feeds output `k`. The whole stage has a single key comparator. Each cycle a round-robin scheduler picks one pair whose two input queues both hold an entry and whose output still has a credit. The stage compares the two queue heads, removes the smaller one and sends it to that pair's output queue.

All input queues share one storage array, and each queue has its own read and write pointers. The comparison result travels through `LAT` pipeline registers before it is written to the output queue. Because the write lands late, room at each output is tracked with a credit counter that starts at `OUT_DEPTH`. Scheduling takes a credit, and a downstream pop gives it back.

Every port carrying data uses valid/ready. An input beat is stored on a clock edge where `in_valid` and `in_ready` are both high. An output beat leaves on an edge where `out_valid` and `out_ready` are both high. While it waits, the output beat holds its value. A beat with `in_last` set is an end marker and its key is ignored. When one side of a pair shows its marker, the other side's records drain through unchanged. When both sides show a marker, the two are replaced by a single output marker, and the pair can then start its next stream.

Top module: `merge_level`

## Requirements
- R1: Records from inputs 2k and 2k+1 appear only on output k. `out_src` is 0 when the record came from the even input of the pair and 1 when it came from the odd input.
- R2: On each output, the keys between two end markers form the merge of the pair's two input streams, in non-decreasing order, with no record lost or added.
- R3: When the two heads hold equal keys and neither is a marker, the record from the even input is emitted first.
- R4: At most one pair is granted the comparator per cycle.
- R5: A pair is granted only when both of its input queues are non-empty and its output has at least one credit. A queue is never popped while empty.
- R6: A marker at one head passes the other side's records through. Two markers at the heads are removed together and produce exactly one output beat with `out_last`=1, key 0 and `out_src`=0. After that, the pair merges its next streams.
- R7: An output queue never takes a write while full, and the credit count never exceeds `OUT_DEPTH`. While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with the same data.
- R8: `in_ready` of an input is low exactly while its queue holds `IN_DEPTH` entries. A beat offered while `in_ready` is low is not stored.
- R9: After reset every output queue is empty (`out_valid`=0) and every `in_ready` is 1.
- R10: If a pair is idle, its output is empty, and both heads are stored on the same edge, the smaller record raises `out_valid` on the (`LAT`+1)-th rising edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2*N_OUT | Input beat valid, one bit per input stream |
| in_ready | output | 2*N_OUT | Input queue has room |
| in_key | input | 2*N_OUT*KEY_W | Input keys, stream i at bits [i*KEY_W +: KEY_W] |
| in_last | input | 2*N_OUT | Beat is an end marker |
| out_valid | output | N_OUT | Output beat valid |
| out_ready | input | N_OUT | Downstream accepts the output beat |
| out_key | output | N_OUT*KEY_W | Output keys, stream k at bits [k*KEY_W +: KEY_W] |
| out_last | output | N_OUT | Output beat is an end marker |
| out_src | output | N_OUT | Side of the pair the record came from |

## Verification
Two events can fall on the same edge for one output: the scheduler taking a credit for a new grant, and a downstream pop returning one. A lost or doubled credit from that collision would overflow the output queue or stall the pair for good. To provoke the collision, some rounds hold `out_ready` high while traffic is dense, so both events happen on nearly every edge. Other rounds use a sparse `out_ready` to keep credits near zero. The result is judged by checking every output beat against a merge computed in the bench, and by requiring that each round drains completely.

// File: rtl/merge_pkg.sv
package merge_pkg;

  typedef enum logic [1:0] {
    PICK_EVEN     = 2'd0,
    PICK_ODD      = 2'd1,
    PICK_BOTH_END = 2'd2
  } pick_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/merge_fifo_bank.sv
module merge_fifo_bank
  import merge_pkg::*;
#(
  parameter int NSTR  = 4,
  parameter int DEPTH = 4,
  parameter int W     = 9,
  parameter int SELW  = idx_width(NSTR / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTR-1:0]   push,
  input  logic [NSTR*W-1:0] push_data,
  input  logic [NSTR-1:0]   pop,
  input  logic [SELW-1:0]   rd_pair,
  output logic [NSTR-1:0]   not_full,
  output logic [NSTR-1:0]   not_empty,
  output logic [W-1:0]      head_even,
  output logic [W-1:0]      head_odd
);
  localparam int PW  = idx_width(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int TOT = NSTR * DEPTH;
  localparam int AW  = idx_width(TOT);
  localparam int SW  = idx_width(NSTR);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem [TOT];
  logic [PW-1:0] wptr [NSTR];
  logic [PW-1:0] rptr [NSTR];
  logic [CW-1:0] cnt  [NSTR];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PLAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] slot(input int s, input logic [PW-1:0] p);
    return AW'(s * DEPTH + int'(p));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSTR; s++) begin
        wptr[s] <= '0;
        rptr[s] <= '0;
        cnt[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < NSTR; s++) begin
        if (push[s]) wptr[s] <= bump(wptr[s]);
        if (pop[s])  rptr[s] <= bump(rptr[s]);
        cnt[s] <= cnt[s] + CW'(push[s]) - CW'(pop[s]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTR; s++) begin
      if (push[s]) mem[slot(s, wptr[s])] <= push_data[s*W +: W];
    end
  end

  always_comb begin
    int e;
    e = 2 * int'(rd_pair);
    if (e + 1 >= NSTR) e = 0;
    head_even = mem[slot(e, rptr[SW'(e)])];
    head_odd  = mem[slot(e + 1, rptr[SW'(e + 1)])];
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_flags
    assign not_full[s]  = (cnt[s] != CFULL);
    assign not_empty[s] = (cnt[s] != '0);

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop[s] |-> (cnt[s] != '0));
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[s] <= CFULL);
    p_full_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[s] == CFULL) && !pop[s] |=> (cnt[s] == CFULL));
  end

endmodule

// File: rtl/merge_rr_arb.sv
module merge_rr_arb
  import merge_pkg::*;
#(
  parameter int N  = 2,
  parameter int IW = idx_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int c;
      c = (int'(last_q) + off) % N;
      if (!gnt_any && req[c]) begin
        gnt[c]  = 1'b1;
        gnt_idx = IW'(c);
        gnt_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end

  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_requested_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_grant_when_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> gnt_any);

endmodule

// File: rtl/merge_out_fifo.sv
module merge_out_fifo
  import merge_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         rdy,
  output logic         vld,
  output logic [W-1:0] rdata,
  output logic         popped
);
  localparam int PW = idx_width(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  assign vld    = (cnt != '0);
  assign popped = vld && rdy;
  assign rdata  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push)   wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      if (popped) rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(popped);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt != CFULL));
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !rdy |=> vld && $stable(rdata));

endmodule

// File: rtl/merge_level.sv
module merge_level
  import merge_pkg::*;
#(
  parameter int N_OUT     = 2,
  parameter int KEY_W     = 8,
  parameter int IN_DEPTH  = 4,
  parameter int OUT_DEPTH = 4,
  parameter int LAT       = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*N_OUT-1:0]         in_valid,
  output logic [2*N_OUT-1:0]         in_ready,
  input  logic [2*N_OUT*KEY_W-1:0]   in_key,
  input  logic [2*N_OUT-1:0]         in_last,
  output logic [N_OUT-1:0]           out_valid,
  input  logic [N_OUT-1:0]           out_ready,
  output logic [N_OUT*KEY_W-1:0]     out_key,
  output logic [N_OUT-1:0]           out_last,
  output logic [N_OUT-1:0]           out_src
);
  localparam int NIN = 2 * N_OUT;
  localparam int EW  = KEY_W + 1;
  localparam int OW  = KEY_W + 2;
  localparam int PRW = idx_width(N_OUT);
  localparam int CRW = $clog2(OUT_DEPTH + 1);
  localparam logic [CRW-1:0] CRMAX = CRW'(OUT_DEPTH);

  logic [NIN-1:0]    push, pop, nfull, nempty;
  logic [NIN*EW-1:0] push_data;
  logic [EW-1:0]     head_e, head_o;
  logic [N_OUT-1:0]  req, gnt, opush, opop;
  logic [PRW-1:0]    gidx;
  logic              gany;
  logic [CRW-1:0]    credit [N_OUT];
  pick_e             pick;
  logic [OW-1:0]     word;

  for (genvar i = 0; i < NIN; i++) begin : g_in
    assign push_data[i*EW +: EW] = {in_last[i], in_key[i*KEY_W +: KEY_W]};
  end
  assign in_ready = nfull;
  assign push     = in_valid & nfull;

  merge_fifo_bank #(.NSTR(NIN), .DEPTH(IN_DEPTH), .W(EW), .SELW(PRW)) bank_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .rd_pair(gidx), .not_full(nfull), .not_empty(nempty),
    .head_even(head_e), .head_odd(head_o)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_req
    assign req[k] = nempty[2*k] && nempty[2*k+1] && (credit[k] != '0);
  end

  merge_rr_arb #(.N(N_OUT), .IW(PRW)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .gnt_idx(gidx), .gnt_any(gany)
  );

  // Single shared comparator; markers rank above every key.
  always_comb begin
    logic a_end, b_end;
    a_end = head_e[KEY_W];
    b_end = head_o[KEY_W];
    if (a_end && b_end)                       pick = PICK_BOTH_END;
    else if (a_end)                           pick = PICK_ODD;
    else if (b_end)                           pick = PICK_EVEN;
    else if (head_e[KEY_W-1:0] <= head_o[KEY_W-1:0]) pick = PICK_EVEN;
    else                                      pick = PICK_ODD;
    case (pick)
      PICK_EVEN: word = {1'b0, 1'b0, head_e[KEY_W-1:0]};
      PICK_ODD:  word = {1'b1, 1'b0, head_o[KEY_W-1:0]};
      default:   word = {1'b0, 1'b1, {KEY_W{1'b0}}};
    endcase
    for (int s = 0; s < NIN; s++) begin
      pop[s] = gany && (int'(gidx) == s / 2) &&
               (((s % 2) == 0) ? (pick != PICK_ODD) : (pick != PICK_EVEN));
    end
  end

  // Fixed-latency path from grant to output write.
  logic           pv [LAT];
  logic [PRW-1:0] pp [LAT];
  logic [OW-1:0]  pd [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) pv[s] <= 1'b0;
    end else begin
      pv[0] <= gany;
      for (int s = 1; s < LAT; s++) pv[s] <= pv[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pp[0] <= gidx;
    pd[0] <= word;
    for (int s = 1; s < LAT; s++) begin
      pp[s] <= pp[s-1];
      pd[s] <= pd[s-1];
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [OW-1:0] rd;

    assign opush[k] = pv[LAT-1] && (pp[LAT-1] == PRW'(k));

    merge_out_fifo #(.DEPTH(OUT_DEPTH), .W(OW)) oq_i (
      .clk(clk), .rst_n(rst_n), .push(opush[k]), .wdata(pd[LAT-1]),
      .rdy(out_ready[k]), .vld(out_valid[k]), .rdata(rd), .popped(opop[k])
    );

    assign out_key[k*KEY_W +: KEY_W] = rd[KEY_W-1:0];
    assign out_last[k]               = rd[KEY_W];
    assign out_src[k]                = rd[KEY_W+1];

    always_ff @(posedge clk) begin
      if (!rst_n) credit[k] <= CRMAX;
      else        credit[k] <= credit[k] - CRW'(gnt[k]) + CRW'(opop[k]);
    end

    p_credit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      credit[k] <= CRMAX);
    p_grant_has_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[k] |-> (credit[k] != '0) && nempty[2*k] && nempty[2*k+1]);
  end

  p_pop_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop != '0) |-> gany);

endmodule

// File: tb/merge_level_tb_top.sv
module merge_level_tb_top;
  localparam int NOUT = 2;
  localparam int KW   = 8;
  localparam int IND  = 4;
  localparam int OUTD = 4;
  localparam int LAT  = 3;
  localparam int NIN  = 2 * NOUT;
  localparam int MAXL = 10;
  localparam int MAXE = 2 * MAXL + 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NIN-1:0]      in_valid = '0;
  logic [NIN-1:0]      in_ready;
  logic [NIN*KW-1:0]   in_key = '0;
  logic [NIN-1:0]      in_last = '0;
  logic [NOUT-1:0]     out_valid;
  logic [NOUT-1:0]     out_ready = '0;
  logic [NOUT*KW-1:0]  out_key;
  logic [NOUT-1:0]     out_last;
  logic [NOUT-1:0]     out_src;

  always #5 clk = ~clk;

  merge_level #(.N_OUT(NOUT), .KEY_W(KW), .IN_DEPTH(IND), .OUT_DEPTH(OUTD), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
    .out_last(out_last), .out_src(out_src)
  );

  int checks = 0;
  int fails  = 0;
  int s_key [NIN][MAXL];
  int s_len [NIN];
  int idx   [NIN];
  int e_key [NOUT][MAXE];
  int e_src [NOUT][MAXE];
  int e_lst [NOUT][MAXE];
  int e_len [NOUT];
  int got   [NOUT];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference merge per pair: ties to even side, then a single end marker.
  function automatic void build_expected();
    for (int k = 0; k < NOUT; k++) begin
      int i, j, n;
      i = 0; j = 0; n = 0;
      while (i < s_len[2*k] || j < s_len[2*k+1]) begin
        if (j >= s_len[2*k+1] || (i < s_len[2*k] && s_key[2*k][i] <= s_key[2*k+1][j])) begin
          e_key[k][n] = s_key[2*k][i]; e_src[k][n] = 0; i++;
        end else begin
          e_key[k][n] = s_key[2*k+1][j]; e_src[k][n] = 1; j++;
        end
        e_lst[k][n] = 0; n++;
      end
      e_key[k][n] = 0; e_src[k][n] = 0; e_lst[k][n] = 1;
      e_len[k] = n + 1;
      got[k] = 0;
    end
  endfunction

  function automatic void random_streams();
    for (int i = 0; i < NIN; i++) begin
      int v;
      s_len[i] = int'($urandom % (MAXL + 1));
      v = int'($urandom % 8);
      for (int m = 0; m < s_len[i]; m++) begin
        s_key[i][m] = v;
        v += int'($urandom % 3);
      end
      idx[i] = 0;
    end
  endfunction

  task automatic run_round(input int pin, input int pout, input string tag);
    bit done;
    int cyc;
    done = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < NIN; i++) begin
        if (idx[i] <= s_len[i] && int'($urandom % 100) < pin) begin
          in_valid[i] = 1'b1;
          in_last[i]  = (idx[i] == s_len[i]);
          in_key[i*KW +: KW] = (idx[i] < s_len[i]) ? KW'(s_key[i][idx[i]]) : '0;
          if (in_ready[i]) idx[i]++;
        end else begin
          in_valid[i] = 1'b0;
        end
      end
      for (int k = 0; k < NOUT; k++) begin
        out_ready[k] = (int'($urandom % 100) < pout);
        if (out_valid[k] && out_ready[k]) begin
          int n, ak;
          n  = got[k];
          ak = int'(out_key[k*KW +: KW]);
          if (n >= e_len[k]) begin
            check(1'b0, "R2 extra beat", ak, -1);
          end else begin
            check(ak == e_key[k][n], $sformatf("R2 key %s out%0d #%0d", tag, k, n), ak, e_key[k][n]);
            check(int'(out_src[k]) == e_src[k][n], $sformatf("R1/R3 src %s out%0d #%0d", tag, k, n),
                  int'(out_src[k]), e_src[k][n]);
            check(int'(out_last[k]) == e_lst[k][n], $sformatf("R6 last %s out%0d #%0d", tag, k, n),
                  int'(out_last[k]), e_lst[k][n]);
          end
          got[k]++;
        end
      end
      done = 1'b1;
      for (int k = 0; k < NOUT; k++) if (got[k] != e_len[k]) done = 1'b0;
      for (int i = 0; i < NIN; i++) if (idx[i] <= s_len[i]) done = 1'b0;
    end
    @(negedge clk);
    in_valid  = '0;
    out_ready = '0;
    for (int k = 0; k < NOUT; k++)
      check(got[k] == e_len[k], $sformatf("R2 drain %s out%0d", tag, k), got[k], e_len[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(out_valid == '0, "R9 out_valid", int'(out_valid), 0);
    check(in_ready == '1, "R9 in_ready", int'(in_ready), (1 << NIN) - 1);

    // R10: latency from storing both heads to out_valid
    for (int i = 0; i < NIN; i++) begin s_len[i] = 0; idx[i] = 0; end
    s_len[0] = 1; s_key[0][0] = 5;
    s_len[1] = 1; s_key[1][0] = 7;
    in_valid[1:0] = 2'b11; in_last[1:0] = 2'b00;
    in_key[0 +: KW] = 8'd5; in_key[KW +: KW] = 8'd7;
    @(negedge clk);
    in_valid = '0;
    idx[0] = 1; idx[1] = 1;
    for (int m = 1; m <= LAT + 1; m++) begin
      @(negedge clk);
      if (m == LAT) check(out_valid[0] == 1'b0, "R10 early", int'(out_valid[0]), 0);
      if (m == LAT + 1) begin
        check(out_valid[0] == 1'b1, "R10 on time", int'(out_valid[0]), 1);
        check(int'(out_key[0 +: KW]) == 5, "R10 key", int'(out_key[0 +: KW]), 5);
      end
    end
    // R7: held while stalled
    @(negedge clk);
    check(out_valid[0] && out_key[0 +: KW] == 8'd5, "R7 hold", int'(out_key[0 +: KW]), 5);
    build_expected();
    run_round(70, 70, "lat");

    // R8: fill input 2 while its partner is empty
    for (int i = 0; i < NIN; i++) begin s_len[i] = 0; idx[i] = 0; end
    s_len[2] = IND;
    for (int m = 0; m < IND; m++) s_key[2][m] = m + 1;
    for (int m = 0; m < IND; m++) begin
      check(in_ready[2] == 1'b1, "R8 ready before full", int'(in_ready[2]), 1);
      in_valid[2] = 1'b1; in_last[2] = 1'b0; in_key[2*KW +: KW] = KW'(m + 1);
      @(negedge clk);
    end
    check(in_ready[2] == 1'b0, "R8 full", int'(in_ready[2]), 0);
    in_key[2*KW +: KW] = 8'd99;
    @(negedge clk);
    check(in_ready[2] == 1'b0, "R8 still full", int'(in_ready[2]), 0);
    in_valid = '0;
    idx[2] = IND;
    build_expected();
    run_round(80, 80, "full");

    // R6: both streams empty give a single marker
    for (int i = 0; i < NIN; i++) begin s_len[i] = 0; idx[i] = 0; end
    build_expected();
    run_round(90, 90, "empty");

    // R3: equal keys on both sides of a pair
    for (int i = 0; i < NIN; i++) begin
      s_len[i] = 3; idx[i] = 0;
      for (int m = 0; m < 3; m++) s_key[i][m] = 4;
    end
    build_expected();
    run_round(100, 100, "tie");

    // Random rounds: dense ready collides credit return with consumption
    for (int r = 0; r < 12; r++) begin
      random_streams();
      build_expected();
      case (r % 3)
        0: run_round(90, 100, $sformatf("rnd%0d", r));
        1: run_round(60, 25, $sformatf("rnd%0d", r));
        default: run_round(30, 80, $sformatf("rnd%0d", r));
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule